// File: doc/BRIEF.md
# Memory-Streaming Block Cipher Sequencer

This block sequences a word-serial block cipher over a fixed buffer of input words. After a start request, it loads the cipher key into the key register once and starts the round-key generator. It then waits until that generator reports that all round keys are ready. After that it walks the input buffer one word at a time. For each word it gives the synchronous input memory one cycle to return data, then runs the round datapath for a fixed number of rounds. It writes the result to the output memory at the matching address and flags the write with a valid strobe.

The round arithmetic, the key schedule and both memories sit outside this block. The sequencer drives only control lines: the key-register load, the schedule start, the round enable, the round-input select, the round index, the write strobe and the two address counters with their enables. A mode input, sampled together with the start request, reverses the round order for decryption. After the last address has been written, the block holds its finished flag until reset.

Top module: `stream_cipher_seq`

## Requirements
- R1: After reset and until `go` is seen high on a clock edge, the block asserts none of `key_load`, `ks_start`, `round_en`, `mem_we`, `valid` or `done`.
- R2: In each run, `key_load` is high for exactly one cycle, in the cycle after `go` is accepted. `ks_start` is high for the single following cycle. No round starts before `ks_ready` has been seen high.
- R3: Each word gets exactly `NUM_ROUNDS` cycles with `round_en` high. When `decrypt` was low at the accepted `go`, `round_idx` runs 0 up to `NUM_ROUNDS-1`. When it was high, the index runs `NUM_ROUNDS-1` down to 0.
- R4: Within the rounds of a word, `use_feedback` is 0 on the first round (take the memory word) and 1 on every later round.
- R5: Each round sequence for a word follows a cycle with `round_en` low, so the memory data read at the current `rd_addr` has had one full cycle to arrive.
- R6: In the cycle after a word's last round, `mem_we` and `valid` are high together for one cycle, at `wr_addr` equal to the word's `rd_addr`.
- R7: The addresses advance by one, through `rd_addr_en` and `wr_addr_en`, only in a write cycle. The run covers addresses 0 to `NUM_WORDS-1`, which is 32 words by default.
- R8: After the write at address `NUM_WORDS-1`, `done` rises and stays high until reset. No further write, round or key load occurs.
- R9: `go` and `decrypt` are ignored once a run has started, and also after `done`.
- R10: Reset at any time returns the block to the idle state, with both addresses at 0 and `done` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Start request, accepted in idle |
| decrypt | input | 1 | Round order select, sampled with `go` |
| ks_ready | input | 1 | Round-key generator reports all keys ready |
| key_load | output | 1 | Load enable for the key register |
| ks_start | output | 1 | Start pulse for the round-key generator |
| round_en | output | 1 | Register the round output this cycle |
| use_feedback | output | 1 | Round input select: 0 memory word, 1 previous round |
| round_idx | output | 4 | Round index for the key selection |
| rd_addr_en | output | 1 | Increment enable of the input address counter |
| wr_addr_en | output | 1 | Increment enable of the output address counter |
| rd_addr | output | 5 | Input memory address |
| wr_addr | output | 5 | Output memory address |
| mem_we | output | 1 | Output memory write enable |
| valid | output | 1 | Result-written strobe |
| done | output | 1 | All words processed, held until reset |

## Verification
The assertions assume a synchronous reset at time zero and a `ks_ready` that, once high, stays high until the next reset. They also assume that the environment supplies memory data exactly one cycle after an address change. The bench raises `ks_ready` a random 1 to 6 cycles after `ks_start` and keeps it high. It models both memories as synchronous arrays with a one-cycle read, and it drives `go` and `decrypt` at random during a run only to exercise R9. Expected results come from a toy order-sensitive round function in the bench. A skipped latency cycle, a wrong first-round select or a reversed order therefore each change the stored words.

// File: rtl/stream_cipher_pkg.sv
package stream_cipher_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_KEY,
        ST_KSTART,
        ST_KWAIT,
        ST_FETCH,
        ST_ROUND,
        ST_WRITE,
        ST_DONE
    } seq_state_t;

    typedef struct packed {
        logic key_load;
        logic ks_start;
        logic round_en;
        logic rnd_init;
        logic adv;
        logic we;
        logic done;
    } seq_ctrl_t;

    function automatic int unsigned clog2_min1(input int unsigned n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/seq_addr_counter.sv
module seq_addr_counter #(
    parameter int unsigned DEPTH = 32,
    parameter int unsigned AW    = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    output logic [AW-1:0] addr,
    output logic          at_last
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    always_ff @(posedge clk) begin
        if (rst)
            addr <= '0;
        else if (en)
            addr <= (addr == LAST) ? '0 : addr + AW'(1);
    end

    assign at_last = (addr == LAST);
endmodule

// File: rtl/seq_round_counter.sv
module seq_round_counter #(
    parameter int unsigned ROUNDS = 10,
    parameter int unsigned RW     = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          init,
    input  logic          step,
    input  logic          down,
    output logic [RW-1:0] idx,
    output logic          last
);
    localparam logic [RW-1:0] TOP = RW'(ROUNDS - 1);

    always_ff @(posedge clk) begin
        if (rst)
            idx <= '0;
        else if (init)
            idx <= down ? TOP : '0;
        else if (step)
            idx <= down ? idx - RW'(1) : idx + RW'(1);
    end

    assign last = down ? (idx == '0) : (idx == TOP);
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
    import stream_cipher_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      go,
    input  logic      decrypt,
    input  logic      ks_ready,
    input  logic      rnd_last,
    input  logic      addr_last,
    output seq_ctrl_t ctrl,
    output logic      dec_mode,
    output logic      first_rnd
);
    seq_state_t state, nxt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            dec_mode  <= 1'b0;
            first_rnd <= 1'b0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE && go)
                dec_mode <= decrypt;
            if (state == ST_FETCH)
                first_rnd <= 1'b1;
            else if (state == ST_ROUND)
                first_rnd <= 1'b0;
        end
    end

    always_comb begin
        nxt  = state;
        ctrl = '0;
        unique case (state)
            ST_IDLE:   if (go) nxt = ST_KEY;
            ST_KEY: begin
                ctrl.key_load = 1'b1;
                nxt = ST_KSTART;
            end
            ST_KSTART: begin
                ctrl.ks_start = 1'b1;
                nxt = ST_KWAIT;
            end
            ST_KWAIT:  if (ks_ready) nxt = ST_FETCH;
            ST_FETCH: begin
                ctrl.rnd_init = 1'b1;
                nxt = ST_ROUND;
            end
            ST_ROUND: begin
                ctrl.round_en = 1'b1;
                if (rnd_last) nxt = ST_WRITE;
            end
            ST_WRITE: begin
                ctrl.we       = 1'b1;
                ctrl.rnd_init = 1'b1;
                if (addr_last) nxt = ST_DONE;
                else begin
                    ctrl.adv = 1'b1;
                    nxt = ST_FETCH;
                end
            end
            ST_DONE:   ctrl.done = 1'b1;
            default:   nxt = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/stream_cipher_seq.sv
module stream_cipher_seq
    import stream_cipher_pkg::*;
#(
    parameter int unsigned NUM_WORDS  = 32,
    parameter int unsigned NUM_ROUNDS = 10,
    localparam int unsigned AW = clog2_min1(NUM_WORDS),
    localparam int unsigned RW = clog2_min1(NUM_ROUNDS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic          decrypt,
    input  logic          ks_ready,
    output logic          key_load,
    output logic          ks_start,
    output logic          round_en,
    output logic          use_feedback,
    output logic [RW-1:0] round_idx,
    output logic          rd_addr_en,
    output logic          wr_addr_en,
    output logic [AW-1:0] rd_addr,
    output logic [AW-1:0] wr_addr,
    output logic          mem_we,
    output logic          valid,
    output logic          done
);
    seq_ctrl_t ctrl;
    logic      dec_mode, first_rnd, rnd_last;
    logic      rd_last, wr_last;

    seq_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .go        (go),
        .decrypt   (decrypt),
        .ks_ready  (ks_ready),
        .rnd_last  (rnd_last),
        .addr_last (wr_last),
        .ctrl      (ctrl),
        .dec_mode  (dec_mode),
        .first_rnd (first_rnd)
    );

    seq_round_counter #(.ROUNDS(NUM_ROUNDS), .RW(RW)) u_rnd (
        .clk  (clk),
        .rst  (rst),
        .init (ctrl.rnd_init),
        .step (ctrl.round_en),
        .down (dec_mode),
        .idx  (round_idx),
        .last (rnd_last)
    );

    seq_addr_counter #(.DEPTH(NUM_WORDS), .AW(AW)) u_rd_addr (
        .clk     (clk),
        .rst     (rst),
        .en      (rd_addr_en),
        .addr    (rd_addr),
        .at_last (rd_last)
    );

    seq_addr_counter #(.DEPTH(NUM_WORDS), .AW(AW)) u_wr_addr (
        .clk     (clk),
        .rst     (rst),
        .en      (wr_addr_en),
        .addr    (wr_addr),
        .at_last (wr_last)
    );

    assign key_load     = ctrl.key_load;
    assign ks_start     = ctrl.ks_start;
    assign round_en     = ctrl.round_en;
    assign use_feedback = ctrl.round_en & ~first_rnd;
    assign rd_addr_en   = ctrl.adv;
    assign wr_addr_en   = ctrl.adv;
    assign mem_we       = ctrl.we;
    assign valid        = ctrl.we;
    assign done         = ctrl.done;

    logic unused_rd_last;
    assign unused_rd_last = rd_last;
endmodule

// File: rtl/stream_cipher_seq_chk.sv
module stream_cipher_seq_chk #(
    parameter int unsigned NUM_WORDS  = 32,
    parameter int unsigned NUM_ROUNDS = 10,
    parameter int unsigned AW = 5,
    parameter int unsigned RW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          go,
    input logic          ks_ready,
    input logic          key_load,
    input logic          ks_start,
    input logic          round_en,
    input logic          use_feedback,
    input logic [RW-1:0] round_idx,
    input logic          rd_addr_en,
    input logic [AW-1:0] rd_addr,
    input logic [AW-1:0] wr_addr,
    input logic          mem_we,
    input logic          valid,
    input logic          done
);
    logic         key_seen, ready_seen;
    logic [RW:0]  rnd_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            key_seen   <= 1'b0;
            ready_seen <= 1'b0;
            rnd_cnt    <= '0;
        end else begin
            if (key_load) key_seen <= 1'b1;
            if (ks_ready && key_seen) ready_seen <= 1'b1;
            if (mem_we) rnd_cnt <= '0;
            else if (round_en) rnd_cnt <= rnd_cnt + 1'b1;
        end
    end

    // R1
    key_after_go_chk: assert property (@(posedge clk) disable iff (rst)
        key_load |-> $past(go));

    // R2
    single_key_load_chk: assert property (@(posedge clk) disable iff (rst)
        key_load |-> !key_seen);

    // R2
    start_after_key_chk: assert property (@(posedge clk) disable iff (rst)
        ks_start |-> $past(key_load));

    // R2
    no_round_before_keys_chk: assert property (@(posedge clk) disable iff (rst)
        round_en |-> ready_seen);

    // R3
    round_idx_range_chk: assert property (@(posedge clk) disable iff (rst)
        round_en |-> (round_idx < RW'(NUM_ROUNDS)));

    // R3
    rounds_per_word_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (rnd_cnt == (RW+1)'(NUM_ROUNDS)));

    // R5
    latency_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (round_en && !use_feedback) |-> !$past(round_en));

    // R6
    write_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (valid && rd_addr == wr_addr && $past(round_en)));

    // R6
    valid_single_chk: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);

    // R7
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        rd_addr_en |=> (rd_addr == AW'($past(rd_addr) + 1'b1)));

    // R8
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> done);

    // R8
    done_last_addr_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (wr_addr == AW'(NUM_WORDS - 1) && !mem_we && !round_en));
endmodule

bind stream_cipher_seq stream_cipher_seq_chk #(
    .NUM_WORDS(NUM_WORDS), .NUM_ROUNDS(NUM_ROUNDS), .AW(AW), .RW(RW)
) u_chk (
    .clk(clk), .rst(rst), .go(go), .ks_ready(ks_ready),
    .key_load(key_load), .ks_start(ks_start), .round_en(round_en),
    .use_feedback(use_feedback), .round_idx(round_idx),
    .rd_addr_en(rd_addr_en), .rd_addr(rd_addr), .wr_addr(wr_addr),
    .mem_we(mem_we), .valid(valid), .done(done)
);

// File: tb/stream_cipher_seq_tb.sv
module stream_cipher_seq_tb_top;
    localparam int NW = 32;
    localparam int NR = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic go = 1'b0, decrypt = 1'b0, ks_ready = 1'b0;
    logic key_load, ks_start, round_en, use_feedback, rd_addr_en, wr_addr_en;
    logic mem_we, valid, done;
    logic [3:0] round_idx;
    logic [4:0] rd_addr, wr_addr;

    always #10 clk = ~clk;

    stream_cipher_seq dut_i (
        .clk(clk), .rst(rst), .go(go), .decrypt(decrypt), .ks_ready(ks_ready),
        .key_load(key_load), .ks_start(ks_start), .round_en(round_en),
        .use_feedback(use_feedback), .round_idx(round_idx),
        .rd_addr_en(rd_addr_en), .wr_addr_en(wr_addr_en),
        .rd_addr(rd_addr), .wr_addr(wr_addr),
        .mem_we(mem_we), .valid(valid), .done(done)
    );

    int checks = 0, errors = 0;
    logic [31:0] in_mem [NW];
    logic [31:0] out_mem [NW];
    logic [31:0] rdata, acc;
    int n_key, n_kstart, n_valid, n_rounds, early_round, ks_delay, ks_cnt;
    logic ks_armed;

    function automatic logic [31:0] mix(input logic [31:0] a, input logic [3:0] r);
        return {a[28:0], a[31:29]} ^ (32'h9E37_79B9 * (32'(r) + 1));
    endfunction

    function automatic logic [31:0] expect_word(input logic [31:0] d, input logic dec);
        logic [31:0] v = d;
        for (int i = 0; i < NR; i++)
            v = mix(v, dec ? 4'(NR - 1 - i) : 4'(i));
        return v;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // environment: memories, toy datapath, key generator
    always @(posedge clk) begin
        rdata <= in_mem[rd_addr];
        if (round_en) acc <= mix(use_feedback ? acc : rdata, round_idx);
        if (mem_we) out_mem[wr_addr] <= acc;
        if (rst) begin
            n_key <= 0; n_kstart <= 0; n_valid <= 0; n_rounds <= 0;
            early_round <= 0; ks_ready <= 1'b0; ks_armed <= 1'b0; ks_cnt <= 0;
        end else begin
            if (key_load) n_key <= n_key + 1;
            if (ks_start) begin n_kstart <= n_kstart + 1; ks_armed <= 1'b1; ks_cnt <= 0; end
            if (ks_armed && !ks_ready) begin
                ks_cnt <= ks_cnt + 1;
                if (ks_cnt + 1 >= ks_delay) ks_ready <= 1'b1;
            end
            if (valid) n_valid <= n_valid + 1;
            if (round_en) n_rounds <= n_rounds + 1;
            if (round_en && !ks_ready) early_round <= early_round + 1;
        end
    end

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; go = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run(input logic dec, input int pattern);
        int cyc;
        for (int i = 0; i < NW; i++) begin
            case (pattern)
                0: in_mem[i] = 32'h0;
                1: in_mem[i] = 32'hFFFF_FFFF;
                default: in_mem[i] = $urandom;
            endcase
            out_mem[i] = 32'hDEAD_BEEF;
        end
        ks_delay = 1 + ($urandom % 6);
        do_reset();
        // R1: idle with go low
        repeat (3) begin
            @(negedge clk);
            check("R1", {31'b0, key_load | ks_start | round_en | mem_we | valid | done}, 0);
        end
        go = 1'b1; decrypt = dec;
        @(negedge clk);
        go = 1'b0; decrypt = ~dec;
        check("R2 key_load", {31'b0, key_load}, 1);
        @(negedge clk);
        check("R2 ks_start", {31'b0, ks_start}, 1);
        cyc = 0;
        while (!done && cyc < 3000) begin
            @(negedge clk);
            cyc++;
            // R9: noise on go/decrypt while busy
            go = 1'($urandom); decrypt = 1'($urandom);
        end
        check("R8 done reached", {31'b0, done}, 1);
        for (int i = 0; i < NW; i++)
            check(dec ? "R3 R4 R5 R6 dec word" : "R3 R4 R5 R6 enc word",
                  out_mem[i], expect_word(in_mem[i], dec));
        check("R2 one key load", n_key, 1);
        check("R9 one ks start", n_kstart, 1);
        check("R2 no early round", early_round, 0);
        check("R7 valid count", n_valid, NW);
        check("R3 round count", n_rounds, NW * NR);
        repeat (20) @(negedge clk);
        go = 1'b0;
        check("R8 done held", {31'b0, done}, 1);
        check("R8 no extra valid", n_valid, NW);
        check("R7 final addr", {27'b0, wr_addr}, NW - 1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        run(1'b0, 2);
        run(1'b1, 2);
        run(1'b0, 0);
        run(1'b1, 1);
        // R10: reset in the middle of a run
        ks_delay = 2;
        do_reset();
        @(negedge clk); go = 1'b1; decrypt = 1'b0;
        @(negedge clk); go = 1'b0;
        repeat (60) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R10 rd_addr", {27'b0, rd_addr}, 0);
        check("R10 wr_addr", {27'b0, wr_addr}, 0);
        check("R10 quiet", {31'b0, done | round_en | mem_we | key_load}, 0);
        run(1'b0, 2);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule